// File: doc/BRIEF.md
# GPIO Direction-Mode Write Lock

This block is one memory-mapped register that guards the direction-mode registers of a set of GPIO banks. Software opens the guard by writing a fixed 16-bit key into the low half of the register and closes it by writing zero there. While the guard is open, the block raises a write-enable line to every bank. Each bank accepts mode-register writes only while that line is high.

The register sits at the lower word of an 8-byte window on a simple single-cycle register bus. The bus carries a byte address, a write strobe and write data, and read data is returned combinationally. The upper word of the window and every address outside it read as zero and ignore writes. The top bit of the register shows whether the lock is held, so competing software owners can see that it is taken. The block does no arbitration beyond that.

Top module: `mode_lock_reg`

## Requirements
- R1: After reset the lock is closed: `mode_we_o` is all zeros and the lock word reads 0x0000_0000.
- R2: A write to the lock word whose bits 15:0 equal the key 0xD42F opens the lock. From the next clock edge, bit 31 of the lock word reads 1 and bits 15:0 read 0xD42F.
- R3: A write to the lock word whose bits 15:0 equal 0x0000 closes the lock. From the next edge, the lock word reads 0x0000_0000.
- R4: A write to the lock word with any other nonzero value in bits 15:0 leaves the lock state unchanged, whether the lock is open or closed.
- R5: Bits 31:16 of the write data play no part in the decision. In particular, writing 1 to bit 31 does not open the lock.
- R6: Bits 30:16 of the lock word always read zero.
- R7: Every bit of `mode_we_o` equals the lock status bit in the same cycle, with no added register stage.
- R8: The lock word is byte offset 0 of the 8-byte window at `BASE_ADDR` (default 0x088). Any other address reads zero and has no effect on the lock when written. This includes offset 4, misaligned offsets and addresses outside the window.
- R9: A cycle with `we_i` low leaves the lock state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W (12) | Byte address of the access |
| we_i | input | 1 | Write strobe, sampled on the rising edge |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data for `addr_i`, combinational |
| mode_we_o | output | NUM_BANKS (3) | Mode-register write enable, one per bank |

## Verification
The assertions assume that `addr_i`, `we_i` and `wdata_i` are stable around the rising edge. They also assume a write is a single-cycle strobe whose effect is judged on the following edge. The bench changes inputs only on falling edges and holds `we_i` for exactly one cycle per write. It samples the outputs on the next falling edge, after the rising edge that commits the write. Reads use a falling-edge address change followed by a short settle delay, because read data is combinational.

// File: rtl/mode_lock_pkg.sv
package mode_lock_pkg;
  localparam logic [15:0] LOCK_KEY_DEFAULT = 16'hD42F;

  typedef enum logic [1:0] {
    KEY_HOLD  = 2'd0,
    KEY_OPEN  = 2'd1,
    KEY_CLOSE = 2'd2
  } key_cmd_e;
endpackage

// File: rtl/mode_lock_decode.sv
module mode_lock_decode #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned WIN_BYTES = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h088
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              win_hit_o,
  output logic              lock_hit_o
);
  localparam int unsigned WIN_LSB = $clog2(WIN_BYTES);

  assign win_hit_o  = (addr_i[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB]);
  // lock word is the aligned first word of the window
  assign lock_hit_o = win_hit_o && (addr_i[WIN_LSB-1:0] == '0);
endmodule

// File: rtl/mode_lock_keychk.sv
module mode_lock_keychk
  import mode_lock_pkg::*;
#(
  parameter int unsigned KEY_W = 16,
  parameter logic [KEY_W-1:0] OPEN_KEY = LOCK_KEY_DEFAULT
) (
  input  logic [KEY_W-1:0] key_i,
  output key_cmd_e         cmd_o
);
  always_comb begin
    if (key_i == OPEN_KEY)  cmd_o = KEY_OPEN;
    else if (key_i == '0)   cmd_o = KEY_CLOSE;
    else                    cmd_o = KEY_HOLD;
  end
endmodule

// File: rtl/mode_lock_state.sv
module mode_lock_state
  import mode_lock_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_i,
  input  key_cmd_e cmd_i,
  output logic     active_o
);
  logic active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
    end else if (wr_i) begin
      case (cmd_i)
        KEY_OPEN:  active_q <= 1'b1;
        KEY_CLOSE: active_q <= 1'b0;
        default:   active_q <= active_q;
      endcase
    end
  end

  assign active_o = active_q;

  // R9: no lock write, no state change
  a_r9_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(active_q));
endmodule

// File: rtl/mode_lock_reg.sv
module mode_lock_reg
  import mode_lock_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned KEY_W     = 16,
  parameter int unsigned WIN_BYTES = 8,
  parameter int unsigned NUM_BANKS = 3,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h088,
  parameter logic [KEY_W-1:0]  OPEN_KEY  = LOCK_KEY_DEFAULT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_BANKS-1:0] mode_we_o
);
  localparam int unsigned STATUS_BIT = DATA_W - 1;

  logic     win_hit, lock_hit, lock_wr, active;
  key_cmd_e cmd;
  logic     unused_wdata_hi;

  assign unused_wdata_hi = ^wdata_i[DATA_W-1:KEY_W];

  mode_lock_decode #(
    .ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES), .BASE_ADDR(BASE_ADDR)
  ) u_decode (
    .addr_i(addr_i), .win_hit_o(win_hit), .lock_hit_o(lock_hit)
  );

  mode_lock_keychk #(
    .KEY_W(KEY_W), .OPEN_KEY(OPEN_KEY)
  ) u_keychk (
    .key_i(wdata_i[KEY_W-1:0]), .cmd_o(cmd)
  );

  assign lock_wr = we_i && lock_hit;

  mode_lock_state u_state (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(lock_wr), .cmd_i(cmd), .active_o(active)
  );

  always_comb begin
    rdata_o = '0;
    if (lock_hit) begin
      rdata_o[STATUS_BIT]  = active;
      rdata_o[KEY_W-1:0]   = active ? OPEN_KEY : '0;
    end
  end

  // same enable to every bank, straight from the status flop
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_we
    assign mode_we_o[b] = active;
  end

  // R2: key opens on the next edge
  a_r2_key_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && lock_hit && wdata_i[KEY_W-1:0] == OPEN_KEY) |=> mode_we_o[0]);

  // R3: zero key closes on the next edge
  a_r3_zero_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && lock_hit && wdata_i[KEY_W-1:0] == '0) |=> !mode_we_o[0]);

  // R4: wrong nonzero key keeps the state
  a_r4_bad_key_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && lock_hit && wdata_i[KEY_W-1:0] != '0 && wdata_i[KEY_W-1:0] != OPEN_KEY)
      |=> $stable(mode_we_o));

  // R7: enable matches status bit seen on the bus
  a_r7_we_is_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_hit |-> (rdata_o[STATUS_BIT] == mode_we_o[0]));

  // R7: all banks share the one enable
  a_r7_banks_equal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_we_o == '0) || (mode_we_o == '1));

  // R8: outside the window nothing reads back
  a_r8_outside_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_hit |-> (rdata_o == '0));

  // R6: middle bits read zero
  a_r6_mid_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[STATUS_BIT-1:KEY_W] == '0);

  // R8: writes off the lock word leave the enable alone
  a_r8_off_word_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !lock_hit) |=> $stable(mode_we_o));
endmodule

// File: tb/sim_mode_lock_reg.sv
module sim_mode_lock_reg;
  localparam logic [11:0] A_LOCK  = 12'h088;
  localparam logic [11:0] A_SPARE = 12'h08C;
  localparam logic [11:0] A_MIS   = 12'h089;
  localparam logic [11:0] A_OUT   = 12'h090;
  localparam logic [11:0] A_LOW   = 12'h080;
  localparam logic [31:0] OPEN_RD = 32'h8000_D42F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  mode_we;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  mode_lock_reg u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .mode_we_o(mode_we)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic we_chk(input string req, input logic exp);
    chk(req, {29'd0, mode_we}, exp ? 32'd7 : 32'd0);
  endtask

  task automatic t_reset;
    we_chk("R1 reset enable", 1'b0);
    rd_chk("R1 reset read", A_LOCK, 32'h0);
  endtask

  task automatic t_open_close;
    wr(A_LOCK, 32'h0000_D42F);
    rd_chk("R2 open read", A_LOCK, OPEN_RD);
    we_chk("R2 open enable", 1'b1);
    wr(A_LOCK, 32'h0000_0000);
    rd_chk("R3 close read", A_LOCK, 32'h0);
    we_chk("R3 close enable", 1'b0);
  endtask

  task automatic t_bad_key;
    wr(A_LOCK, 32'h0000_1234);
    rd_chk("R4 bad key while closed", A_LOCK, 32'h0);
    wr(A_LOCK, 32'h0000_D42F);
    wr(A_LOCK, 32'h0000_D42E);
    rd_chk("R4 near key while open", A_LOCK, OPEN_RD);
    wr(A_LOCK, 32'h0000_FFFF);
    we_chk("R4 all-ones key while open", 1'b1);
  endtask

  task automatic t_upper_bits;
    wr(A_LOCK, 32'hFFFF_0000);
    rd_chk("R5 upper ones with zero key closes", A_LOCK, 32'h0);
    wr(A_LOCK, 32'h8000_0001);
    rd_chk("R5 bit31 does not open", A_LOCK, 32'h0);
    wr(A_LOCK, 32'h7FFF_D42F);
    rd_chk("R6 middle bits read zero", A_LOCK, OPEN_RD);
  endtask

  task automatic t_window;
    // lock is open on entry
    wr(A_SPARE, 32'h0000_0000);
    we_chk("R8 spare word write ignored", 1'b1);
    rd_chk("R8 spare word reads zero", A_SPARE, 32'h0);
    wr(A_MIS, 32'h0000_0000);
    we_chk("R8 misaligned write ignored", 1'b1);
    rd_chk("R8 misaligned reads zero", A_MIS, 32'h0);
    wr(A_OUT, 32'h0000_0000);
    rd_chk("R8 outside reads zero", A_OUT, 32'h0);
    wr(A_LOW, 32'h0000_0000);
    rd_chk("R8 lock word still open", A_LOCK, OPEN_RD);
    wr(A_LOCK, 32'h0);
    wr(A_SPARE, 32'h0000_D42F);
    we_chk("R8 key at spare does not open", 1'b0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    addr = A_LOCK; wdata = 32'h0000_D42F; we = 1'b0;
    repeat (3) @(negedge clk);
    we_chk("R9 key without strobe", 1'b0);
    wdata = '0;
  endtask

  task automatic t_same_cycle;
    // R7: enable and status change on the same edge
    @(negedge clk);
    addr = A_LOCK; wdata = 32'h0000_D42F; we = 1'b1;
    @(posedge clk);
    #1;
    chk("R7 status after edge", {31'd0, rdata[31]}, 32'd1);
    we_chk("R7 enable same cycle", 1'b1);
    @(negedge clk);
    we = 1'b0;
    wdata = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_open_close;
    t_bad_key;
    t_upper_bits;
    t_window;
    t_idle;
    t_same_cycle;
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule